// File: doc/BRIEF.md
# Programmable Display Scan Timing Generator

This block produces the raster timing for a display from values that software writes at run time. A small word-addressed register file holds a control word, a status word, one packed timing word for each axis, a packed word with both totals, and two frame-buffer base addresses. From these the core runs a pixel counter and a line counter. It decodes horizontal and vertical sync, and a video-active gate, from the counters. It pulses once at the end of each frame and presents the base address of the buffer that is currently on screen.

Software clears the run bit, programs the timing and base words, then sets the run bit again. Each axis passes through four phases: sync, back porch, visible region and front porch. The sync, porch and visible fields are written as length minus one. The totals are written as real counts, and the front porch is whatever is left of the total. The core copies the timing and total words into shadow registers at each frame start, so a rewrite during a frame never tears the picture. With page flipping enabled, the output base address swaps between the two buffers at every frame boundary, which is also where vertical sync begins.

Top module: `scan_timing_gen`

## Requirements
- R1: After reset, and with no register written, pix_x and line_y are 0, video_active and frame_end are 0, hsync_o and vsync_o are 1, fb_base is 0, and every register reads 0.
- R2: While running, pix_x counts 0 to Htotal-1, one step per clock, then wraps to 0. line_y advances by one at each pix_x wrap and wraps to 0 after Vtotal-1. Htotal is bits 31:16 of the word at 0x10 and Vtotal is bits 15:0 of that word.
- R3: Horizontal sync is asserted while pix_x <= S, where S is bits 31:24 of the horizontal timing word at 0x08. Vertical sync is asserted while line_y <= S of the vertical timing word at 0x0C. By default both syncs are active-low.
- R4: video_active is 1 exactly when both axes are inside their visible window. For each axis the window runs from count S+D+2 to count S+D+G+2 inclusive, where D is bits 23:16 and G is bits 15:0 of that axis's timing word.
- R5: Control bit 0 is the run bit. From the clock after it is cleared, both syncs are at their inactive level, video_active and frame_end are 0, and fb_base shows buffer A. From the next clock on, pix_x and line_y stay at 0.
- R6: frame_end is high for exactly one clock while running: the clock in which pix_x = Htotal-1 and line_y = Vtotal-1.
- R7: Status bit 0 is set by frame_end and stays set until software writes a 1 to status bit 0 (address 0x04). Status bit 1 reads 1 while buffer B is the one shown.
- R8: When control bit 1 is set, fb_base swaps between the base at 0x14 (A) and the base at 0x18 (B) on the clock after each frame_end. When control bit 1 is clear, fb_base stays at the buffer that was shown at the last frame start. Starting the core always begins on A.
- R9: The words at 0x00 (control, bits 3:0), 0x08, 0x0C, 0x10, 0x14 and 0x18 read back the value last written.
- R10: Timing and total words written while running take effect only at the next frame start. Setting the run bit loads the current values.
- R11: Control bit 2 makes horizontal sync active-high and control bit 3 makes vertical sync active-high. When the core is stopped, each sync rests at the inverse of its active level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one word per clock |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| hsync_o | output | 1 | Horizontal sync pin level |
| vsync_o | output | 1 | Vertical sync pin level |
| video_active | output | 1 | Visible-pixel gate |
| pix_x | output | 16 | Pixel counter within the line |
| line_y | output | 16 | Line counter within the frame |
| frame_end | output | 1 | One-clock pulse on the last pixel of a frame |
| fb_base | output | BASE_W | Base address of the buffer being shown |

## Verification
The bench predicts every output on every clock across whole frames. It uses a tiny mode, so that the off-by-one edges of sync and gate fall on pixels it checks: a design that treated a field as the real length, instead of length minus one, would shift the gate by a pixel and miscompare there. The bench rewrites the total and visible width in the middle of a frame, then expects the old geometry until the wrap. A design that applied the words at once would stretch the current line. It also checks that the buffer swaps only after the frame pulse, and that the status flag survives until it is written back with a one. A design that swapped early, or cleared the flag on read, would show the wrong base or lose the event. Stopping mid-frame must park the counters at zero and the pins at idle, and the polarity bits must invert each sync on its own.

// File: rtl/stg_pkg.sv
// Shared constants and types for the scan timing generator.
// Assumes a 32-bit register word and 16-bit counters (fixed by the packing).
package stg_pkg;
    localparam int CNT_W   = 16;
    localparam int CTL_W   = 4;

    // Word indices (byte address bits 4:2)
    localparam logic [2:0] IDX_CTRL = 3'd0;
    localparam logic [2:0] IDX_STAT = 3'd1;
    localparam logic [2:0] IDX_HTIM = 3'd2;
    localparam logic [2:0] IDX_VTIM = 3'd3;
    localparam logic [2:0] IDX_TOT  = 3'd4;
    localparam logic [2:0] IDX_BASA = 3'd5;
    localparam logic [2:0] IDX_BASB = 3'd6;

    // Control bit positions
    localparam int CTL_RUN  = 0;
    localparam int CTL_FLIP = 1;
    localparam int CTL_HPOL = 2;
    localparam int CTL_VPOL = 3;

    // One axis: sync, back porch and visible length, each stored minus one
    typedef struct packed {
        logic [7:0]       sync;
        logic [7:0]       dly;
        logic [CNT_W-1:0] vis;
    } axis_t;
endpackage

// File: rtl/stg_regs.sv
// Register file: control, sticky status, timing words and two base addresses.
// Assumes single-word writes with the byte address word-aligned; reads are combinational.
module stg_regs
    import stg_pkg::*;
#(
    parameter int BASE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        addr,
    input  logic [31:0]       wdata,
    input  logic              we,
    input  logic              frame_end,
    input  logic              sel,
    output logic [31:0]       rdata,
    output logic [CTL_W-1:0]  ctrl,
    output logic [31:0]       htim,
    output logic [31:0]       vtim,
    output logic [31:0]       tot,
    output logic [BASE_W-1:0] base_a,
    output logic [BASE_W-1:0] base_b
);
    logic       eof_flag;
    logic       wr_ok;
    logic [2:0] idx;

    assign idx   = addr[4:2];
    assign wr_ok = we && (addr[1:0] == 2'b00);

    // Write path for the plain storage words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '0;
            htim   <= '0;
            vtim   <= '0;
            tot    <= '0;
            base_a <= '0;
            base_b <= '0;
        end else if (wr_ok) begin
            case (idx)
                IDX_CTRL: ctrl   <= wdata[CTL_W-1:0];
                IDX_HTIM: htim   <= wdata;
                IDX_VTIM: vtim   <= wdata;
                IDX_TOT:  tot    <= wdata;
                IDX_BASA: base_a <= wdata[BASE_W-1:0];
                IDX_BASB: base_b <= wdata[BASE_W-1:0];
                default: ;
            endcase
        end
    end

    // Sticky end-of-frame flag: set wins over a write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            eof_flag <= 1'b0;
        else if (frame_end)
            eof_flag <= 1'b1;
        else if (wr_ok && idx == IDX_STAT && wdata[0])
            eof_flag <= 1'b0;
    end

    // Read mux
    always_comb begin
        case (idx)
            IDX_CTRL: rdata = 32'(ctrl);
            IDX_STAT: rdata = {30'd0, sel, eof_flag};
            IDX_HTIM: rdata = htim;
            IDX_VTIM: rdata = vtim;
            IDX_TOT:  rdata = tot;
            IDX_BASA: rdata = 32'(base_a);
            IDX_BASB: rdata = 32'(base_b);
            default:  rdata = '0;
        endcase
    end

    a_r7_eof_sets: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> eof_flag);
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && idx == IDX_STAT && wdata[0] && !frame_end) |=> !eof_flag);
endmodule

// File: rtl/stg_axis.sv
// Phase decoder for one axis: sync window and visible window from a counter.
// Assumes fields hold length minus one; purely combinational.
module stg_axis
    import stg_pkg::*;
(
    input  logic [CNT_W-1:0] cnt,
    input  axis_t            cfg,
    output logic             in_sync,
    output logic             in_gate
);
    localparam int EW = CNT_W + 2;
    logic [EW-1:0] cnt_x;
    logic [EW-1:0] first_px;
    logic [EW-1:0] last_px;

    // Window edges in widened arithmetic so no sum can wrap
    always_comb begin
        cnt_x    = EW'(cnt);
        first_px = EW'(cfg.sync) + EW'(cfg.dly) + EW'(2);
        last_px  = first_px + EW'(cfg.vis);
        in_sync  = cnt_x <= EW'(cfg.sync);
        in_gate  = (cnt_x >= first_px) && (cnt_x <= last_px);
    end
endmodule

// File: rtl/stg_scan.sv
// Pixel/line counters, per-frame shadow copies of the timing words, buffer select.
// Assumes totals of at least 2; live words are copied while stopped and at each frame wrap.
module stg_scan
    import stg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             flip,
    input  logic [31:0]      htim,
    input  logic [31:0]      vtim,
    input  logic [31:0]      tot,
    output logic [CNT_W-1:0] hcnt,
    output logic [CNT_W-1:0] vcnt,
    output axis_t            h_cfg,
    output axis_t            v_cfg,
    output logic             frame_end,
    output logic             sel
);
    logic [31:0]      htim_sh;
    logic [31:0]      vtim_sh;
    logic [31:0]      tot_sh;
    logic [CNT_W-1:0] htot;
    logic [CNT_W-1:0] vtot;
    logic             h_last;
    logic             v_last;

    assign htot      = tot_sh[31:16];
    assign vtot      = tot_sh[15:0];
    assign h_last    = hcnt == htot - 1'b1;
    assign v_last    = vcnt == vtot - 1'b1;
    assign frame_end = run && h_last && v_last;
    assign h_cfg     = axis_t'(htim_sh);
    assign v_cfg     = axis_t'(vtim_sh);

    // Raster walk, shadow reload at frame start, page toggle at frame wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt    <= '0;
            vcnt    <= '0;
            sel     <= 1'b0;
            htim_sh <= '0;
            vtim_sh <= '0;
            tot_sh  <= '0;
        end else if (!run) begin
            hcnt    <= '0;
            vcnt    <= '0;
            sel     <= 1'b0;
            htim_sh <= htim;
            vtim_sh <= vtim;
            tot_sh  <= tot;
        end else if (h_last) begin
            hcnt <= '0;
            if (v_last) begin
                vcnt    <= '0;
                sel     <= sel ^ flip;
                htim_sh <= htim;
                vtim_sh <= vtim;
                tot_sh  <= tot;
            end else begin
                vcnt <= vcnt + 1'b1;
            end
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    a_r2_h_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (run && htot != '0) |-> (hcnt < htot));
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (hcnt == '0 && vcnt == '0));
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && htot > 16'd1) |=> !frame_end);
    a_r8_sel_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != $past(sel)) |-> ($past(frame_end) || !$past(run)));
endmodule

// File: rtl/scan_timing_gen.sv
// Top: register file, raster counters and two axis decoders driving the pins.
// Assumes software stops the core before changing polarity if glitch-free pins matter.
module scan_timing_gen
    import stg_pkg::*;
#(
    parameter int BASE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_we,
    output logic [31:0]       reg_rdata,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              video_active,
    output logic [CNT_W-1:0]  pix_x,
    output logic [CNT_W-1:0]  line_y,
    output logic              frame_end,
    output logic [BASE_W-1:0] fb_base
);
    logic [CTL_W-1:0]  ctrl;
    logic [31:0]       htim, vtim, tot;
    logic [BASE_W-1:0] base_a, base_b;
    logic              run, sel;
    axis_t             ax_cfg  [2];
    logic [CNT_W-1:0]  ax_cnt  [2];
    logic              ax_sync [2];
    logic              ax_gate [2];

    assign run = ctrl[CTL_RUN];

    stg_regs #(.BASE_W(BASE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
        .frame_end(frame_end), .sel(sel), .rdata(reg_rdata), .ctrl(ctrl),
        .htim(htim), .vtim(vtim), .tot(tot), .base_a(base_a), .base_b(base_b)
    );

    stg_scan u_scan (
        .clk(clk), .rst_n(rst_n), .run(run), .flip(ctrl[CTL_FLIP]),
        .htim(htim), .vtim(vtim), .tot(tot), .hcnt(pix_x), .vcnt(line_y),
        .h_cfg(ax_cfg[0]), .v_cfg(ax_cfg[1]), .frame_end(frame_end), .sel(sel)
    );

    assign ax_cnt[0] = pix_x;
    assign ax_cnt[1] = line_y;

    // One decoder per axis
    for (genvar g = 0; g < 2; g++) begin : g_axis
        stg_axis u_axis (
            .cnt(ax_cnt[g]), .cfg(ax_cfg[g]),
            .in_sync(ax_sync[g]), .in_gate(ax_gate[g])
        );
    end

    // Pin levels: polarity applied, idle level when stopped
    always_comb begin
        hsync_o      = run ? (ax_sync[0] ~^ ctrl[CTL_HPOL]) : !ctrl[CTL_HPOL];
        vsync_o      = run ? (ax_sync[1] ~^ ctrl[CTL_VPOL]) : !ctrl[CTL_VPOL];
        video_active = run && ax_gate[0] && ax_gate[1];
        fb_base      = (run && sel) ? base_b : base_a;
    end

    a_r3_hsync_gate_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(ax_sync[0] && ax_gate[0]));
    a_r4_gate_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        video_active |-> run);
    a_r5_stopped_pins_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (hsync_o != ctrl[CTL_HPOL] && !video_active && !frame_end));
endmodule

// File: tb/scan_timing_gen_test.sv
// Scoreboard bench: a driver task predicts every output per clock into a queue;
// a monitor pops and compares at each falling edge.
module scan_timing_gen_test;
    localparam logic [31:0] BA = 32'h1000_0000;
    localparam logic [31:0] BB = 32'h1000_1000;
    localparam logic [31:0] HT1 = {8'd1, 8'd0, 16'd3};
    localparam logic [31:0] VT1 = {8'd0, 8'd0, 16'd1};
    localparam logic [31:0] TO1 = {16'd10, 16'd5};
    localparam logic [31:0] HT2 = {8'd1, 8'd0, 16'd4};
    localparam logic [31:0] TO2 = {16'd12, 16'd5};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic        hsync_o, vsync_o, video_active, frame_end;
    logic [15:0] pix_x, line_y;
    logic [31:0] fb_base;

    scan_timing_gen uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .video_active(video_active), .pix_x(pix_x), .line_y(line_y),
        .frame_end(frame_end), .fb_base(fb_base)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic        hs, vs, act, fe;
        logic [15:0] x, y;
        logic [31:0] base;
    } exp_t;
    typedef struct {
        int hs, hd, hg, ht, vs, vd, vg, vt;
    } tm_t;

    exp_t  q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    string phase = "R2";
    string sync_tag = "R3";
    tm_t   sh, lv;
    int    mh, mv;
    bit    msel, mflip, mhpol, mvpol;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s/%s actual=%h expected=%h t=%0t", phase, tag, act, exp, $time);
        end
    endtask

    function automatic tm_t mk(logic [31:0] h, logic [31:0] v, logic [31:0] t);
        tm_t r;
        r.hs = int'(h[31:24]); r.hd = int'(h[23:16]); r.hg = int'(h[15:0]); r.ht = int'(t[31:16]);
        r.vs = int'(v[31:24]); r.vd = int'(v[23:16]); r.vg = int'(v[15:0]); r.vt = int'(t[15:0]);
        return r;
    endfunction

    // Driver: predict n clocks from the requirements and queue them
    task automatic push_cycles(int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            bit hsa, vsa, hga, vga;
            hsa = mh <= sh.hs;
            vsa = mv <= sh.vs;
            hga = (mh >= sh.hs + sh.hd + 2) && (mh <= sh.hs + sh.hd + sh.hg + 2);
            vga = (mv >= sh.vs + sh.vd + 2) && (mv <= sh.vs + sh.vd + sh.vg + 2);
            e.hs   = mhpol ? hsa : !hsa;
            e.vs   = mvpol ? vsa : !vsa;
            e.act  = hga && vga;
            e.fe   = (mh == sh.ht - 1) && (mv == sh.vt - 1);
            e.x    = 16'(mh);
            e.y    = 16'(mv);
            e.base = msel ? BB : BA;
            q.push_back(e);
            if (mh == sh.ht - 1) begin
                mh = 0;
                if (mv == sh.vt - 1) begin
                    mv = 0;
                    msel ^= mflip;
                    sh = lv;
                end else mv++;
            end else mh++;
        end
    endtask

    // Monitor: compare design outputs against the queued prediction
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(sync_tag, 32'(hsync_o), 32'(e.hs));
            chk(sync_tag, 32'(vsync_o), 32'(e.vs));
            chk("R4", 32'(video_active), 32'(e.act));
            chk("R2", 32'(pix_x), 32'(e.x));
            chk("R2", 32'(line_y), 32'(e.y));
            chk("R6", 32'(frame_end), 32'(e.fe));
            chk("R8", fb_base, e.base);
        end
    end

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic start_model(bit flip, bit hp, bit vp);
        mh = 0; mv = 0; msel = 0;
        mflip = flip; mhpol = hp; mvpol = vp;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired t=%0t", $time);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state at the pins and in the registers
        @(negedge clk);
        phase = "R1";
        chk("R1", 32'(hsync_o), 32'd1);
        chk("R1", 32'(vsync_o), 32'd1);
        chk("R1", 32'(video_active), 32'd0);
        chk("R1", 32'(frame_end), 32'd0);
        chk("R1", 32'(pix_x), 32'd0);
        chk("R1", 32'(line_y), 32'd0);
        chk("R1", fb_base, 32'd0);
        for (int a = 0; a < 7; a++) begin
            rd(5'(a * 4), d);
            chk("R1", d, 32'd0);
        end

        // R9: program the map and read it back
        phase = "R9";
        wr(5'h08, HT1); wr(5'h0C, VT1); wr(5'h10, TO1);
        wr(5'h14, BA);  wr(5'h18, BB);  wr(5'h00, 32'h0000_00F4);
        rd(5'h08, d); chk("R9", d, HT1);
        rd(5'h0C, d); chk("R9", d, VT1);
        rd(5'h10, d); chk("R9", d, TO1);
        rd(5'h14, d); chk("R9", d, BA);
        rd(5'h18, d); chk("R9", d, BB);
        rd(5'h00, d); chk("R9", d, 32'h4);
        wr(5'h00, 32'h0);

        // R2/R3/R4/R6/R8: run with page flipping over one frame and a bit
        phase = "R8";
        sh = mk(HT1, VT1, TO1); lv = sh;
        wr(5'h00, 32'h3);
        start_model(1, 0, 0);
        push_cycles(55);
        wait (q.size() == 0);

        // R7: sticky flag and shown buffer, then write-one clear
        phase = "R7";
        rd(5'h04, d); chk("R7", d, 32'h3);
        wr(5'h04, 32'h1);
        rd(5'h04, d); chk("R7", d, 32'h2);

        // R5: stop mid-frame
        phase = "R5";
        wr(5'h00, 32'h0);
        @(negedge clk);
        chk("R5", 32'(hsync_o), 32'd1);
        chk("R5", 32'(vsync_o), 32'd1);
        chk("R5", 32'(video_active), 32'd0);
        chk("R5", 32'(frame_end), 32'd0);
        chk("R5", fb_base, BA);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R5", 32'(pix_x), 32'd0);
            chk("R5", 32'(line_y), 32'd0);
        end

        // R10: rewrite width and total mid-frame; old geometry holds until the wrap
        phase = "R10";
        sh = mk(HT1, VT1, TO1); lv = mk(HT2, VT1, TO2);
        wr(5'h00, 32'h1);
        start_model(0, 0, 0);
        push_cycles(80);
        repeat (8) @(negedge clk);
        wr(5'h08, HT2);
        wr(5'h10, TO2);
        wait (q.size() == 0);
        wr(5'h00, 32'h0);

        // R11: both syncs active-high
        phase = "R11";
        sync_tag = "R11";
        @(negedge clk);
        sh = mk(HT2, VT1, TO2); lv = sh;
        wr(5'h00, 32'hD);
        start_model(0, 1, 1);
        push_cycles(70);
        wait (q.size() == 0);
        wr(5'h00, 32'hC);
        @(negedge clk);
        chk("R11", 32'(hsync_o), 32'd0);
        chk("R11", 32'(vsync_o), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule